// File: doc/BRIEF.md
# Back-to-Back Wakeup and Select Scheduler

This block holds the waiting instructions of one single-cycle functional unit. Each slot keeps a destination tag and, for two sources, either a value or the tag of the producer it waits for. Every cycle the lowest-numbered slot whose sources are all satisfied is picked. Its operands are registered toward the unit, and its slot is released at the same clock edge.

Dependent instructions run on consecutive cycles. The picked instruction's destination tag goes to every slot in the cycle it is picked, one cycle before the unit produces its result. A consumer woken by that early tag can be picked in the next cycle. Its missing operand is then taken straight from the unit output, which in that cycle carries the producer's result. A woken consumer that loses selection in that cycle latches the unit output anyway, so no value is lost.

Results of other, longer units arrive on a separate late result bus and are captured by tag. A flush empties every slot in one cycle.

Top module: `wake_sched`

## Requirements
- R1: `disp_ready_o` is 1 exactly when at least one slot is free. A dispatch offered while it is 0 is dropped and never issues. A slot becomes free at the clock edge that ends the cycle it is picked in.
- R2: In a cycle without flush and with at least one ready slot, `wake_valid_o` is 1, and in the next cycle `iss_valid_o` is 1 with `iss_tag_o` equal to that `wake_tag_o`. With no ready slot, `wake_valid_o` is 0 and `iss_valid_o` is 0 in the next cycle.
- R3: Among ready slots the lowest-numbered one is picked. A new instruction is written into the lowest-numbered free slot.
- R4: `wake_tag_o` is the destination tag of the instruction picked in that cycle. The unit's result for it appears on `fu_result_i` one cycle later.
- R5: A waiting source whose tag equals `wake_tag_o` is satisfied from the next cycle on, including a source of an instruction dispatched in that same cycle.
- R6: A source satisfied by the early tag takes `fu_result_i` in the cycle after its producer was picked. It uses that value directly if picked in that cycle, and otherwise keeps it for a later pick.
- R7: Three instructions, each depending on the one before and otherwise ready, issue on three consecutive cycles.
- R8: A waiting source whose tag equals `wb_tag_i` while `wb_valid_i` is 1 captures `wb_data_i` and is satisfied from the next cycle on. This also holds in the dispatch cycle.
- R9: A dispatched source whose tag equals `iss_tag_o` while `iss_valid_o` is 1 captures `fu_result_i` in the dispatch cycle.
- R10: No slot is picked while one of its sources is unsatisfied. A source dispatched as ready carries its supplied value to the unit unchanged.
- R11: While `flush_i` is 1, nothing is picked (`wake_valid_o` 0) and any dispatch is dropped. In the next cycle every slot is free and `iss_valid_o` is 0.
- R12: After reset every slot is free, `disp_ready_o` is 1, and `iss_valid_o` and `wake_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty all slots, cancel this cycle's pick and dispatch |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | A slot is free |
| disp_dst_i | input | TAG_W | Destination tag of the dispatched instruction |
| disp_src0_rdy_i | input | 1 | Source 0 value is supplied |
| disp_src0_tag_i | input | TAG_W | Producer tag of source 0 |
| disp_src0_val_i | input | DATA_W | Value of source 0 |
| disp_src1_rdy_i | input | 1 | Source 1 value is supplied |
| disp_src1_tag_i | input | TAG_W | Producer tag of source 1 |
| disp_src1_val_i | input | DATA_W | Value of source 1 |
| wb_valid_i | input | 1 | Late result bus valid |
| wb_tag_i | input | TAG_W | Late result tag |
| wb_data_i | input | DATA_W | Late result value |
| fu_result_i | input | DATA_W | Unit output for the instruction issued one cycle earlier |
| wake_valid_o | output | 1 | Early tag broadcast valid (select cycle) |
| wake_tag_o | output | TAG_W | Early tag: destination of the picked instruction |
| iss_valid_o | output | 1 | Operands to the unit are valid |
| iss_tag_o | output | TAG_W | Destination tag of the issued instruction |
| iss_a_o | output | DATA_W | Operand A to the unit |
| iss_b_o | output | DATA_W | Operand B to the unit |

## Verification
A slot that believes a source is satisfied too early shows in the very cycle it becomes eligible. `wake_valid_o` or `wake_tag_o` then differs from the model, and a cycle later the operand on `iss_a_o` or `iss_b_o` is wrong. A source whose bypass capture is missed or mistimed carries a stale value that appears only when that slot is finally picked, which may be several cycles later when a lower slot wins first. The bench therefore compares every output on every cycle against a tag-timing model, so the first divergent cycle is the one reported. Flush and full-buffer faults show as a slot issuing that should not exist.

// File: rtl/sched_pkg.sv
package sched_pkg;
    // per-source readiness: waiting for a tag, value on unit output this cycle, value held
    typedef enum logic [1:0] {
        SRC_WAIT = 2'd0,
        SRC_BYP  = 2'd1,
        SRC_HAVE = 2'd2
    } src_st_e;

    localparam int unsigned NSRC = 2;
endpackage

// File: rtl/pick_lowest.sv
module pick_lowest #(
    parameter int unsigned N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);
    localparam logic [N-1:0] ONE = N'(1);

    logic found;

    always_comb begin
        gnt_o = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                gnt_o[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assign any_o = |req_i;

    // R3: at most one grant
    p_onehot_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));
    // R3: no requester below the granted one
    p_lowest_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((gnt_o - ONE) & req_i) == '0);
    // R2: a request always yields a grant
    p_grant_when_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_o |-> (gnt_o != '0));
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import sched_pkg::*;
#(
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        flush_i,
    input  logic                        alloc_i,
    input  logic [TAG_W-1:0]            alloc_dst_i,
    input  logic [NSRC-1:0]             alloc_rdy_i,
    input  logic [NSRC-1:0][TAG_W-1:0]  alloc_tag_i,
    input  logic [NSRC-1:0][DATA_W-1:0] alloc_val_i,
    input  logic                        sel_i,
    input  logic                        wake_valid_i,
    input  logic [TAG_W-1:0]            wake_tag_i,
    input  logic                        prev_valid_i,
    input  logic [TAG_W-1:0]            prev_tag_i,
    input  logic [DATA_W-1:0]           fu_result_i,
    input  logic                        wb_valid_i,
    input  logic [TAG_W-1:0]            wb_tag_i,
    input  logic [DATA_W-1:0]           wb_data_i,
    output logic                        busy_o,
    output logic                        ready_o,
    output logic [TAG_W-1:0]            dst_o,
    output logic [NSRC-1:0][DATA_W-1:0] opnd_o
);
    typedef struct {
        logic              busy;
        logic [TAG_W-1:0]  dst;
        src_st_e           st  [NSRC];
        logic [TAG_W-1:0]  tag [NSRC];
        logic [DATA_W-1:0] val [NSRC];
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int s = 0; s < NSRC; s++) begin
            if (s_q.busy) begin
                unique case (s_q.st[s])
                    SRC_WAIT: begin
                        if (wake_valid_i && s_q.tag[s] == wake_tag_i) begin
                            s_d.st[s] = SRC_BYP;
                        end else if (wb_valid_i && s_q.tag[s] == wb_tag_i) begin
                            s_d.st[s]  = SRC_HAVE;
                            s_d.val[s] = wb_data_i;
                        end
                    end
                    SRC_BYP: begin
                        s_d.st[s]  = SRC_HAVE;
                        s_d.val[s] = fu_result_i;
                    end
                    default: ;
                endcase
            end
        end
        if (sel_i) begin
            s_d.busy = 1'b0;
        end
        if (alloc_i) begin
            s_d.busy = 1'b1;
            s_d.dst  = alloc_dst_i;
            for (int s = 0; s < NSRC; s++) begin
                s_d.tag[s] = alloc_tag_i[s];
                s_d.val[s] = alloc_val_i[s];
                if (alloc_rdy_i[s]) begin
                    s_d.st[s] = SRC_HAVE;
                end else if (wake_valid_i && alloc_tag_i[s] == wake_tag_i) begin
                    s_d.st[s] = SRC_BYP;
                end else if (prev_valid_i && alloc_tag_i[s] == prev_tag_i) begin
                    s_d.st[s]  = SRC_HAVE;
                    s_d.val[s] = fu_result_i;
                end else if (wb_valid_i && alloc_tag_i[s] == wb_tag_i) begin
                    s_d.st[s]  = SRC_HAVE;
                    s_d.val[s] = wb_data_i;
                end else begin
                    s_d.st[s] = SRC_WAIT;
                end
            end
        end
        if (flush_i) begin
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.busy <= 1'b0;
            s_q.dst  <= '0;
            for (int s = 0; s < NSRC; s++) begin
                s_q.st[s]  <= SRC_WAIT;
                s_q.tag[s] <= '0;
                s_q.val[s] <= '0;
            end
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ready_o = s_q.busy;
        for (int s = 0; s < NSRC; s++) begin
            if (s_q.st[s] == SRC_WAIT) ready_o = 1'b0;
            // bypass mux: a source woken by the early tag reads the unit output
            opnd_o[s] = (s_q.st[s] == SRC_HAVE) ? s_q.val[s] : fu_result_i;
        end
    end

    assign busy_o = s_q.busy;
    assign dst_o  = s_q.dst;

    // R10: picked only when every source is satisfied
    p_pick_needs_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_i |-> ready_o);
    // R1: slot released after its pick
    p_free_after_pick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_i |=> !busy_o);
    // R6: bypass state lasts one cycle, then the value is held
    p_byp_src0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.busy && s_q.st[0] == SRC_BYP) |=> s_q.st[0] == SRC_HAVE);
    p_byp_src1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.busy && s_q.st[1] == SRC_BYP) |=> s_q.st[1] == SRC_HAVE);
endmodule

// File: rtl/wake_sched.sv
module wake_sched
    import sched_pkg::*;
#(
    parameter int unsigned NUM_ENT = 4,
    parameter int unsigned TAG_W   = 4,
    parameter int unsigned DATA_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              disp_valid_i,
    output logic              disp_ready_o,
    input  logic [TAG_W-1:0]  disp_dst_i,
    input  logic              disp_src0_rdy_i,
    input  logic [TAG_W-1:0]  disp_src0_tag_i,
    input  logic [DATA_W-1:0] disp_src0_val_i,
    input  logic              disp_src1_rdy_i,
    input  logic [TAG_W-1:0]  disp_src1_tag_i,
    input  logic [DATA_W-1:0] disp_src1_val_i,
    input  logic              wb_valid_i,
    input  logic [TAG_W-1:0]  wb_tag_i,
    input  logic [DATA_W-1:0] wb_data_i,
    input  logic [DATA_W-1:0] fu_result_i,
    output logic              wake_valid_o,
    output logic [TAG_W-1:0]  wake_tag_o,
    output logic              iss_valid_o,
    output logic [TAG_W-1:0]  iss_tag_o,
    output logic [DATA_W-1:0] iss_a_o,
    output logic [DATA_W-1:0] iss_b_o
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } iss_t;

    iss_t iss_d, iss_q;

    logic [NUM_ENT-1:0]                        busy, ready, sel_gnt, free_gnt;
    logic [NUM_ENT-1:0][TAG_W-1:0]             dst;
    logic [NUM_ENT-1:0][NSRC-1:0][DATA_W-1:0]  opnd;
    logic                                      any_ready, any_free;
    logic                                      alloc_go, sel_en;
    logic [NSRC-1:0]                           a_rdy;
    logic [NSRC-1:0][TAG_W-1:0]                a_tag;
    logic [NSRC-1:0][DATA_W-1:0]               a_val;
    logic [TAG_W-1:0]                          sel_tag;
    logic [NSRC-1:0][DATA_W-1:0]               sel_opnd;

    assign a_rdy = {disp_src1_rdy_i, disp_src0_rdy_i};
    assign a_tag = {disp_src1_tag_i, disp_src0_tag_i};
    assign a_val = {disp_src1_val_i, disp_src0_val_i};

    pick_lowest #(.N(NUM_ENT)) u_pick_issue (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (ready),
        .gnt_o  (sel_gnt),
        .any_o  (any_ready)
    );

    pick_lowest #(.N(NUM_ENT)) u_pick_free (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (~busy),
        .gnt_o  (free_gnt),
        .any_o  (any_free)
    );

    assign alloc_go = disp_valid_i && any_free && !flush_i;
    assign sel_en   = any_ready && !flush_i;

    for (genvar k = 0; k < NUM_ENT; k++) begin : g_slot
        rs_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .flush_i      (flush_i),
            .alloc_i      (alloc_go && free_gnt[k]),
            .alloc_dst_i  (disp_dst_i),
            .alloc_rdy_i  (a_rdy),
            .alloc_tag_i  (a_tag),
            .alloc_val_i  (a_val),
            .sel_i        (sel_en && sel_gnt[k]),
            .wake_valid_i (wake_valid_o),
            .wake_tag_i   (wake_tag_o),
            .prev_valid_i (iss_q.valid),
            .prev_tag_i   (iss_q.tag),
            .fu_result_i  (fu_result_i),
            .wb_valid_i   (wb_valid_i),
            .wb_tag_i     (wb_tag_i),
            .wb_data_i    (wb_data_i),
            .busy_o       (busy[k]),
            .ready_o      (ready[k]),
            .dst_o        (dst[k]),
            .opnd_o       (opnd[k])
        );
    end

    always_comb begin
        sel_tag  = '0;
        sel_opnd = '0;
        for (int k = 0; k < NUM_ENT; k++) begin
            if (sel_gnt[k]) begin
                sel_tag  = sel_tag | dst[k];
                sel_opnd = sel_opnd | opnd[k];
            end
        end
        iss_d.valid = sel_en;
        iss_d.tag   = sel_tag;
        iss_d.a     = sel_opnd[0];
        iss_d.b     = sel_opnd[1];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            iss_q <= '0;
        end else begin
            iss_q <= iss_d;
        end
    end

    assign disp_ready_o = any_free;
    assign wake_valid_o = sel_en;
    assign wake_tag_o   = sel_tag;
    assign iss_valid_o  = iss_q.valid;
    assign iss_tag_o    = iss_q.tag;
    assign iss_a_o      = iss_q.a;
    assign iss_b_o      = iss_q.b;

    // R2/R4: early tag is followed by the issue of that same tag
    p_issue_follows_wake_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_valid_o |=> (iss_valid_o && iss_tag_o == $past(wake_tag_o)));
    p_idle_no_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wake_valid_o |=> !iss_valid_o);
    // R11: flush blocks the pick and empties the slots
    p_flush_no_wake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> !wake_valid_o);
    p_flush_empties_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (disp_ready_o && !iss_valid_o));
    // R1: a full buffer refuses dispatch and keeps its occupancy
    p_full_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!disp_ready_o && !wake_valid_o && !flush_i) |=> !disp_ready_o);
endmodule

// File: tb/wake_sched_test.sv
module wake_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam int NT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        disp_valid = 1'b0;
    logic        disp_ready;
    logic [3:0]  disp_dst = '0;
    logic        s0_rdy = 1'b0, s1_rdy = 1'b0;
    logic [3:0]  s0_tag = '0, s1_tag = '0;
    logic [15:0] s0_val = '0, s1_val = '0;
    logic        wb_valid = 1'b0;
    logic [3:0]  wb_tag = '0;
    logic [15:0] wb_data = '0;
    logic [15:0] fu_result;
    logic        wake_valid, iss_valid;
    logic [3:0]  wake_tag, iss_tag;
    logic [15:0] iss_a, iss_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    // the functional unit: single-cycle add on the issued operands
    assign fu_result = iss_a + iss_b;

    wake_sched uut (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .disp_valid_i(disp_valid), .disp_ready_o(disp_ready), .disp_dst_i(disp_dst),
        .disp_src0_rdy_i(s0_rdy), .disp_src0_tag_i(s0_tag), .disp_src0_val_i(s0_val),
        .disp_src1_rdy_i(s1_rdy), .disp_src1_tag_i(s1_tag), .disp_src1_val_i(s1_val),
        .wb_valid_i(wb_valid), .wb_tag_i(wb_tag), .wb_data_i(wb_data),
        .fu_result_i(fu_result),
        .wake_valid_o(wake_valid), .wake_tag_o(wake_tag),
        .iss_valid_o(iss_valid), .iss_tag_o(iss_tag), .iss_a_o(iss_a), .iss_b_o(iss_b)
    );

    int checks = 0;
    int fails = 0;
    int now = 0;
    bit done = 0;

    // reference model: slots with per-source knowledge, plus tag timing tables
    bit          m_busy [NE];
    logic [3:0]  m_dst  [NE];
    bit          m_have [NE][2];
    logic [3:0]  m_tag  [NE][2];
    logic [15:0] m_val  [NE][2];
    int          sel_cyc [NT];
    logic [15:0] res     [NT];
    int          wb_cyc  [NT];
    logic [15:0] wbv     [NT];
    int          dut_wake_cyc [NT];
    bit          exp_v = 0;
    logic [3:0]  exp_tag;
    logic [15:0] exp_a, exp_b;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, now);
        end
    endtask

    function automatic bit src_ok(int k, int s);
        int t = int'(m_tag[k][s]);
        if (m_have[k][s]) return 1;
        if (sel_cyc[t] >= 0 && sel_cyc[t] < now) return 1;
        if (wb_cyc[t] >= 0 && wb_cyc[t] < now) return 1;
        return 0;
    endfunction

    function automatic logic [15:0] src_val(int k, int s);
        int t = int'(m_tag[k][s]);
        if (m_have[k][s]) return m_val[k][s];
        if (sel_cyc[t] >= 0 && sel_cyc[t] < now) return res[t];
        return wbv[t];
    endfunction

    task automatic tick();
        int sel = -1;
        int fslot = -1;
        logic [15:0] a, b;
        #1;
        if (!flush)
            for (int k = 0; k < NE; k++)
                if (sel < 0 && m_busy[k] && src_ok(k, 0) && src_ok(k, 1)) sel = k;
        for (int k = 0; k < NE; k++)
            if (fslot < 0 && !m_busy[k]) fslot = k;
        chk(disp_ready == (fslot >= 0), "R1 disp_ready", int'(disp_ready), int'(fslot >= 0));
        chk(wake_valid == (sel >= 0), "R2 wake_valid (R10 no early pick)", int'(wake_valid), int'(sel >= 0));
        if (sel >= 0 && wake_valid)
            chk(wake_tag == m_dst[sel], "R4 wake tag of lowest ready slot R3", int'(wake_tag), int'(m_dst[sel]));
        chk(iss_valid == exp_v, "R2 iss_valid", int'(iss_valid), int'(exp_v));
        if (exp_v && iss_valid) begin
            chk(iss_tag == exp_tag, "R2 iss_tag", int'(iss_tag), int'(exp_tag));
            chk(iss_a == exp_a, "R6 operand a", int'(iss_a), int'(exp_a));
            chk(iss_b == exp_b, "R6 operand b", int'(iss_b), int'(exp_b));
        end
        if (wake_valid) dut_wake_cyc[wake_tag] = now;
        if (flush) begin
            for (int k = 0; k < NE; k++) m_busy[k] = 0;
            exp_v = 0;
        end else begin
            if (sel >= 0) begin
                a = src_val(sel, 0);
                b = src_val(sel, 1);
                exp_v = 1; exp_tag = m_dst[sel]; exp_a = a; exp_b = b;
                sel_cyc[m_dst[sel]] = now;
                res[m_dst[sel]] = a + b;
                m_busy[sel] = 0;
            end else begin
                exp_v = 0;
            end
            if (disp_valid && fslot >= 0) begin
                m_busy[fslot] = 1;
                m_dst[fslot] = disp_dst;
                m_have[fslot][0] = s0_rdy; m_tag[fslot][0] = s0_tag; m_val[fslot][0] = s0_val;
                m_have[fslot][1] = s1_rdy; m_tag[fslot][1] = s1_tag; m_val[fslot][1] = s1_val;
            end
        end
        if (wb_valid) begin
            wb_cyc[wb_tag] = now;
            wbv[wb_tag] = wb_data;
        end
        now++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        disp_valid = 0; wb_valid = 0; flush = 0;
    endtask

    task automatic disp(input logic [3:0] d, input bit r0, input logic [3:0] t0, input logic [15:0] v0,
                        input bit r1, input logic [3:0] t1, input logic [15:0] v1);
        disp_valid = 1; disp_dst = d;
        s0_rdy = r0; s0_tag = t0; s0_val = v0;
        s1_rdy = r1; s1_tag = t1; s1_val = v1;
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin
            sel_cyc[t] = -1; wb_cyc[t] = -1; dut_wake_cyc[t] = -1; res[t] = '0; wbv[t] = '0;
        end
        for (int k = 0; k < NE; k++) m_busy[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(disp_ready == 1'b1, "R12 reset disp_ready", int'(disp_ready), 1);
        chk(iss_valid == 1'b0, "R12 reset iss_valid", int'(iss_valid), 0);
        chk(wake_valid == 1'b0, "R12 reset wake_valid", int'(wake_valid), 0);

        // R7 chain; R5 wake in dispatch cycle; R9 capture of unit output at dispatch
        disp(4'd1, 1, 4'd0, 16'd10, 1, 4'd0, 16'd20); tick();
        disp(4'd2, 0, 4'd1, 16'd0, 1, 4'd0, 16'd5);   tick();
        disp(4'd3, 0, 4'd2, 16'd0, 0, 4'd1, 16'd0);   tick();
        idle(); repeat (4) tick();
        chk(dut_wake_cyc[2] == dut_wake_cyc[1] + 1, "R7 second link back-to-back", dut_wake_cyc[2], dut_wake_cyc[1] + 1);
        chk(dut_wake_cyc[3] == dut_wake_cyc[2] + 1, "R7 third link back-to-back R5", dut_wake_cyc[3], dut_wake_cyc[2] + 1);

        // R1 full buffer, R8 late bus release, R3 slot order, R10 no early pick
        disp(4'd4, 0, 4'd15, 16'd0, 1, 4'd0, 16'd1); tick();
        disp(4'd5, 0, 4'd15, 16'd0, 1, 4'd0, 16'd2); tick();
        disp(4'd6, 0, 4'd15, 16'd0, 1, 4'd0, 16'd3); tick();
        disp(4'd7, 0, 4'd15, 16'd0, 1, 4'd0, 16'd4); tick();
        chk(disp_ready == 1'b0, "R1 full buffer not ready", int'(disp_ready), 0);
        chk(wake_valid == 1'b0, "R10 no pick while waiting", int'(wake_valid), 0);
        disp(4'd8, 1, 4'd0, 16'd9, 1, 4'd0, 16'd9); tick();
        idle(); wb_valid = 1; wb_tag = 4'd15; wb_data = 16'd100; tick();
        idle(); repeat (6) tick();
        chk(dut_wake_cyc[8] == -1, "R1 dropped dispatch never issues", dut_wake_cyc[8], -1);
        chk(dut_wake_cyc[5] == dut_wake_cyc[4] + 1 && dut_wake_cyc[6] == dut_wake_cyc[5] + 1
            && dut_wake_cyc[7] == dut_wake_cyc[6] + 1, "R3 lowest slot first", dut_wake_cyc[7], dut_wake_cyc[4] + 3);
        chk(dut_wake_cyc[4] == wb_cyc[15] + 1, "R8 late bus wakes next cycle", dut_wake_cyc[4], wb_cyc[15] + 1);

        // R6 woken consumer loses one pick and uses the held bypass value later
        disp(4'd9, 0, 4'd14, 16'd0, 1, 4'd0, 16'd3);  tick();
        disp(4'd10, 0, 4'd14, 16'd0, 1, 4'd0, 16'd4); tick();
        disp(4'd11, 0, 4'd9, 16'd0, 1, 4'd0, 16'd7);  tick();
        idle(); wb_valid = 1; wb_tag = 4'd14; wb_data = 16'd50; tick();
        idle(); repeat (5) tick();
        chk(dut_wake_cyc[10] == dut_wake_cyc[9] + 1, "R3 lower slot wins over woken consumer", dut_wake_cyc[10], dut_wake_cyc[9] + 1);
        chk(dut_wake_cyc[11] == dut_wake_cyc[10] + 1, "R6 held bypass value issue", dut_wake_cyc[11], dut_wake_cyc[10] + 1);

        // R11 flush cancels a ready slot and a dispatch in the same cycle
        disp(4'd12, 1, 4'd0, 16'd1, 1, 4'd0, 16'd1); tick();
        idle(); flush = 1; disp(4'd13, 1, 4'd0, 16'd2, 1, 4'd0, 16'd2); tick();
        idle();
        chk(disp_ready == 1'b1, "R11 all free after flush", int'(disp_ready), 1);
        repeat (4) tick();
        chk(dut_wake_cyc[12] == -1, "R11 flushed slot never issues", dut_wake_cyc[12], -1);
        chk(dut_wake_cyc[13] == -1, "R11 dispatch in flush dropped", dut_wake_cyc[13], -1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule